// File: doc/BRIEF.md
# Kick-Edge Watchdog Timer

This block measures the time that has passed since software last proved it was alive. Software proves this by driving a low-to-high transition on an asynchronous kick line. The elapsed time is counted in units of an external millisecond tick. A 3-bit period code either selects one of five doubling periods or turns the timer off. If the selected period runs out with no kick edge, the block emits a one-cycle expiry pulse. A neighbouring reset controller turns that pulse into system resets on every reset output.

After an expiry the timer parks and stops counting. It stays parked until the reset controller strobes that the stretched resets have been released. The count then restarts from zero. Only an edge clears the count, so a kick line stuck high or stuck low keeps producing expiries. Each expiry is separated from the next by the period plus the reset stretch.

Top module: `kick_watchdog`

## Requirements
- R1: After reset the expiry output is low, the count is zero and the timer is in the counting state.
- R2: Period code c in 3..7 gives an expiry on the (BASE_TICKS * 2^(c-3))-th millisecond tick after the count was last cleared. With the default BASE_TICKS of 400 this is 400, 800, 1600, 3200 or 6400 ms.
- R3: Only a low-to-high transition of the kick input clears the count. A kick level held high or held low does not prevent expiry.
- R4: Period codes 0, 1 and 2 disable the timer. The count is held at zero and no expiry is produced, so a later switch back on starts counting from zero.
- R5: After an expiry the timer waits for the release strobe. The strobe clears the count and resumes counting, so with no kicks the expiries repeat, one period after each release.
- R6: While waiting for release, ticks do not advance the count and kick edges are ignored.
- R7: The expiry output is a single-cycle high pulse.
- R8: The kick input is asynchronous. It passes through a two-flop synchronizer, and a rising edge clears the count within three clock edges of the change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ms_tick | input | 1 | One-cycle strobe per millisecond |
| kick_in | input | 1 | Asynchronous kick line; a rising edge restarts the period |
| period_sel | input | 3 | Period code: 0-2 off, 3-7 selects a period |
| rst_release | input | 1 | One-cycle strobe: the resets have been released |
| expire | output | 1 | One-cycle pulse when the period has elapsed |

## Verification
The hardest situation to reach is the parked state after an expiry. Ticks and kick edges arrive there that must have no effect, and a period change can land in the middle of a count. The stimulus reaches this by letting expiries happen with the kick line stuck high and stuck low. It then keeps issuing ticks, kicks and code changes before the release strobe. A seeded random mix of ticks, kicks, code changes and releases follows, checked against a bench model that counts ticks since the last clearing event.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  typedef enum logic {
    ST_COUNT = 1'b0,
    ST_PARKED = 1'b1
  } wdt_state_e;

  localparam int unsigned CODE_FIRST_ON = 3;

  // Number of ms ticks in the period picked by code; 0 means disabled.
  function automatic int unsigned period_ticks(input logic [2:0] code,
                                               input int unsigned base);
    int unsigned shift;
    if (code < 3'(CODE_FIRST_ON)) begin
      return 0;
    end
    shift = int'(code) - CODE_FIRST_ON;
    return base << shift;
  endfunction

endpackage

// File: rtl/wdt_kick_sync.sv
module wdt_kick_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kick_async,
  output logic kick_rise
);

  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[0] <= 1'b0;
          else        sync_q[0] <= kick_async;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[g] <= 1'b0;
          else        sync_q[g] <= sync_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sync_q[STAGES-1];
  end

  assign kick_rise = sync_q[STAGES-1] & ~prev_q;

  // R8: a detected edge lasts exactly one cycle
  a_r8_rise_single : assert property (@(posedge clk) disable iff (!rst_n)
    kick_rise |=> !kick_rise);

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             enable,
  input  logic             clear,
  input  logic [CNT_W-1:0] limit,
  output logic             hit,
  output logic [CNT_W-1:0] count
);

  logic [CNT_W:0] next_val;
  logic           disabled;

  assign disabled = (limit == '0);
  assign next_val = {1'b0, count} + 1'b1;
  assign hit      = enable && tick && !disabled && !clear &&
                    (next_val >= {1'b0, limit});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (clear || disabled || hit) begin
      count <= '0;
    end else if (enable && tick) begin
      count <= next_val[CNT_W-1:0];
    end
  end

  // R6: the count stays put while the timer is not counting
  a_r6_parked_stable : assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !clear) |=> $stable(count));

  // R4: a disabled period leaves the count at zero
  a_r4_off_zero : assert property (@(posedge clk) disable iff (!rst_n)
    (disabled && $past(disabled)) |-> (count == '0));

endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic release_i,
  output logic counting,
  output logic expire_o
);

  wdt_state_e state_q;

  assign counting = (state_q == ST_COUNT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_COUNT;
      expire_o <= 1'b0;
    end else begin
      expire_o <= 1'b0;
      if (release_i) begin
        state_q <= ST_COUNT;
      end else if (counting && hit) begin
        state_q  <= ST_PARKED;
        expire_o <= 1'b1;
      end
    end
  end

  // R7: expiry never lasts two cycles
  a_r7_single_pulse : assert property (@(posedge clk) disable iff (!rst_n)
    expire_o |=> !expire_o);

  // R5: an expiry is always followed by the parked state until release
  a_r5_expire_parks : assert property (@(posedge clk) disable iff (!rst_n)
    (expire_o && !release_i) |-> !counting);

  // R6: no expiry can come out of the parked state
  a_r6_parked_silent : assert property (@(posedge clk) disable iff (!rst_n)
    !counting |=> !expire_o);

endmodule

// File: rtl/kick_watchdog.sv
module kick_watchdog #(
  parameter int unsigned BASE_TICKS  = 400,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ms_tick,
  input  logic       kick_in,
  input  logic [2:0] period_sel,
  input  logic       rst_release,
  output logic       expire
);

  localparam int unsigned MAX_TICKS = BASE_TICKS * 16;
  localparam int unsigned CNT_W     = $clog2(MAX_TICKS + 1);

  logic             kick_rise;
  logic             counting;
  logic             hit;
  logic             clear;
  logic [CNT_W-1:0] limit;
  logic [CNT_W-1:0] count;

  assign limit = CNT_W'(wdt_pkg::period_ticks(period_sel, BASE_TICKS));
  assign clear = rst_release || (kick_rise && counting);

  wdt_kick_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .kick_async (kick_in),
    .kick_rise  (kick_rise)
  );

  wdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (ms_tick),
    .enable (counting),
    .clear  (clear),
    .limit  (limit),
    .hit    (hit),
    .count  (count)
  );

  wdt_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .hit       (hit),
    .release_i (rst_release),
    .counting  (counting),
    .expire_o  (expire)
  );

  // R4: an off code produces no expiry in the next cycle
  a_r4_off_no_expire : assert property (@(posedge clk) disable iff (!rst_n)
    (period_sel < 3'd3) |=> !expire);

  // R3: an accepted kick edge blocks an expiry in the next cycle
  a_r3_kick_blocks : assert property (@(posedge clk) disable iff (!rst_n)
    (kick_rise && counting) |=> !expire);

  // R1: the count never exceeds the largest period
  a_r1_count_bound : assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(MAX_TICKS));

endmodule

// File: tb/kick_watchdog_bench.sv
module kick_watchdog_bench;

  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned BASE       = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ms_tick = 1'b0;
  logic       kick_in = 1'b0;
  logic [2:0] period_sel = 3'd3;
  logic       rst_release = 1'b0;
  logic       expire;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  // bench model
  int  m_count = 0;
  bit  m_parked = 0;
  int  m_limit = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  kick_watchdog #(.BASE_TICKS(BASE)) u_kick_watchdog (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .kick_in(kick_in),
    .period_sel(period_sel), .rst_release(rst_release), .expire(expire)
  );

  // Period in ticks built by repeated doubling, 0 when off.
  function automatic int exp_period(input int code);
    int p;
    if (code <= 2) return 0;
    p = BASE;
    for (int k = 3; k < code; k++) p = p + p;
    return p;
  endfunction

  task automatic check(input logic act, input logic expv, input string req);
    tests++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: expire=%0b expected %0b at %0t", req, act, expv, $time);
    end
  endtask

  task automatic idle(input string req);
    @(negedge clk);
    check(expire, 1'b0, req);
  endtask

  task automatic do_tick(input string req);
    logic e;
    e = 1'b0;
    if (!m_parked && m_limit != 0) begin
      m_count++;
      if (m_count >= m_limit) begin
        e = 1'b1; m_count = 0; m_parked = 1;
      end
    end
    ms_tick = 1'b1;
    @(negedge clk);
    ms_tick = 1'b0;
    check(expire, e, req);
    idle("R7");
  endtask

  task automatic ticks(input int n, input string req);
    for (int i = 0; i < n; i++) do_tick(req);
  endtask

  task automatic set_code(input int code);
    period_sel = 3'(code);
    m_limit = exp_period(code);
    if (m_limit == 0) m_count = 0;
    idle("R4");
  endtask

  task automatic kick_rise_only;
    kick_in = 1'b1;
    if (!m_parked) m_count = 0;
    for (int i = 0; i < 4; i++) idle("R8");
  endtask

  task automatic kick_pulse;
    kick_rise_only();
    kick_in = 1'b0;
    idle("R8"); idle("R8");
  endtask

  task automatic release_strobe;
    rst_release = 1'b1;
    @(negedge clk);
    rst_release = 1'b0;
    check(expire, 1'b0, "R5");
    m_parked = 0; m_count = 0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    m_limit = exp_period(3);
    repeat (3) @(negedge clk);
    check(expire, 1'b0, "R1");
    rst_n = 1'b1;
    idle("R1"); idle("R1");

    // R2: first period, code 3
    ticks(BASE, "R2");
    // R6: parked, ticks and kicks do nothing
    ticks(3 * BASE, "R6");
    kick_pulse();
    ticks(2, "R6");
    // R5: release restarts, free-running expiries
    release_strobe();
    ticks(BASE, "R5");
    release_strobe();
    ticks(BASE, "R5");
    release_strobe();

    // R3: kick edge clears mid-count
    ticks(BASE - 1, "R3");
    kick_pulse();
    ticks(BASE - 1, "R3");
    ticks(1, "R3");
    release_strobe();
    // R3: kick held high still times out
    kick_rise_only();
    ticks(BASE, "R3");
    release_strobe();
    ticks(BASE, "R3");
    kick_in = 1'b0;
    idle("R3"); idle("R3");
    release_strobe();
    ticks(BASE, "R3");
    release_strobe();

    // R4: off codes
    for (int c = 0; c < 3; c++) begin
      set_code(c);
      ticks(20 * BASE, "R4");
    end
    set_code(3);
    ticks(BASE - 1, "R4");
    set_code(0);
    set_code(3);
    ticks(BASE - 1, "R4");
    ticks(1, "R4");
    release_strobe();

    // R2: the remaining periods
    for (int c = 4; c < 8; c++) begin
      set_code(c);
      ticks(exp_period(c), "R2");
      release_strobe();
    end

    // random mix
    for (int it = 0; it < 1500; it++) begin
      int act;
      act = int'($urandom % 12);
      if (act < 7)       do_tick("R2");
      else if (act == 7) kick_pulse();
      else if (act == 8) set_code(int'($urandom % 8));
      else if (act == 9) release_strobe();
      else if (act == 10 && m_parked) release_strobe();
      else               idle("R7");
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule